// File: doc/BRIEF.md
# USB Bus-Reset Register Reinitializer

This block is the software-visible register file of a USB device controller, together with the logic that returns it to Default-state values when the line-state logic reports a bus reset. The bus reset is separate from the chip reset. It clears only a chosen set of registers: the device address, the endpoint index, the endpoint-0 control/status register, and the four IN/OUT control/status registers of every other endpoint. In the same cycle it pulses a flush to every endpoint FIFO. It also reloads the interrupt-enable mask to a fixed pattern.

Each bus reset sets a sticky reset flag. If that source is enabled, the reset also sets a chip-level USB flag. The interrupt line is driven only while a global enable is also set, so the request passes through two enables in series. The CPU reaches all registers through a simple port with a 4-bit address. Writes take effect at the clock edge. Reads are combinational.

Register map (address: content):
- 0: device address, bits [6:0].
- 1: endpoint index, low bits.
- 2: common interrupt flags, read-to-clear. Bit 2 is the reset flag.
- 3: interrupt-enable mask. Bit 0 is suspend, bit 1 is resume, bit 2 is reset and bit 3 is start-of-frame.
- 4: chip flag at bit 0, cleared by writing 1 to it.
- 5: global enable at bit 0.
- 6: endpoint-0 control/status register.
- 7 to 10: IN low, IN high, OUT low and OUT high control/status registers of the endpoint selected by the index. Index 0 reads these as 0 and ignores writes to them.
- All other addresses read 0.

Top module: `usb_busreset_regs`

## Requirements
- R1: A cycle with `bus_rst_i` high sets the reset flag (register 2, bit 2) from the next cycle on. A CPU read of register 2 clears the flag at that clock edge. If a bus reset falls in the same cycle as the read, the flag stays set.
- R2: A bus reset sets the chip flag (register 4, bit 0) when mask bit 2 is 1 in that cycle. Writing 1 to register 4 bit 0 clears the chip flag, and a bus reset in the same cycle wins. `irq_o` is high exactly when both the chip flag and the global enable (register 5, bit 0) are 1.
- R3: The device address register is 7 bits wide. A CPU write is readable from the next cycle. A bus reset sets it to 0.
- R4: A bus reset sets the endpoint index register to 0.
- R5: `flush_o` has every bit high in each cycle in which `bus_rst_i` is high, and is all zero otherwise.
- R6: A bus reset clears the endpoint-0 register and the IN low, IN high, OUT low and OUT high registers of every endpoint.
- R7: A bus reset loads the mask with 4'b0110, which enables every source except start-of-frame (bit 3) and suspend (bit 0).
- R8: Bus resets in consecutive cycles, or separated by CPU writes, each repeat the whole reinitialization.
- R9: A CPU write in the same cycle as a bus reset has no effect on registers 0, 1, 3, 6, 7, 8, 9 and 10.
- R10: After chip reset, every register reads 0 except the mask, which reads 4'b0110, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| bus_rst_i | input | 1 | One-cycle bus-reset detect pulse |
| cpu_addr | input | 4 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe, used for read-to-clear |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |
| flush_o | output | NUM_EP | Per-endpoint FIFO flush pulse |
| irq_o | output | 1 | Chip-level USB interrupt request |

## Verification
A register that fails to clear shows up one cycle after the reset pulse. It appears as a nonzero read-back of the address, the index or an endpoint register through the normal read port. A wrong flag or enable chain appears on `irq_o` and on registers 2 and 4 in the cycle after the event. A wrong flush appears on `flush_o` within the same cycle. The bench sweeps every address value, every mask pattern under both global-enable settings, and every endpoint register under each index. This covers every field that the reset touches.

// File: rtl/usb_busreset_regs.sv
module usb_busreset_regs #(
  parameter int NUM_EP = 4,
  parameter int IDX_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  parameter logic [3:0] RST_MASK = 4'b0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_i,
  input  logic [3:0]        cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic [NUM_EP-1:0] flush_o,
  output logic              irq_o
);

  localparam logic [3:0] A_ADDR = 4'd0, A_IDX = 4'd1, A_CIF = 4'd2, A_CIE = 4'd3,
                         A_CHF = 4'd4, A_GEN = 4'd5, A_EP0 = 4'd6, A_INL = 4'd7,
                         A_INH = 4'd8, A_OUTL = 4'd9, A_OUTH = 4'd10;

  logic [6:0]       dev_addr;
  logic [IDX_W-1:0] idx;
  logic             rst_flag;
  logic [3:0]       ie_mask;
  logic             chip_flag;
  logic             glb_en;
  logic [7:0]       ep0cs;
  logic [7:0]       inl  [NUM_EP];
  logic [7:0]       inh  [NUM_EP];
  logic [7:0]       outl [NUM_EP];
  logic [7:0]       outh [NUM_EP];

  wire ep_sel   = (idx != '0);
  wire rd_cif   = cpu_rd && cpu_addr == A_CIF;
  wire clr_chip = cpu_wr && cpu_addr == A_CHF && cpu_wdata[0];

  assign flush_o = {NUM_EP{bus_rst_i}};
  assign irq_o   = chip_flag & glb_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr  <= '0;
      idx       <= '0;
      ie_mask   <= RST_MASK;
      ep0cs     <= '0;
      rst_flag  <= 1'b0;
      chip_flag <= 1'b0;
      glb_en    <= 1'b0;
      for (int e = 0; e < NUM_EP; e++) begin
        inl[e] <= '0; inh[e] <= '0; outl[e] <= '0; outh[e] <= '0;
      end
    end else begin
      rst_flag  <= bus_rst_i | (rst_flag & ~rd_cif);
      chip_flag <= (bus_rst_i & ie_mask[2]) | (chip_flag & ~clr_chip);
      if (cpu_wr && cpu_addr == A_GEN) glb_en <= cpu_wdata[0];
      if (bus_rst_i) begin
        dev_addr <= '0;
        idx      <= '0;
        ie_mask  <= RST_MASK;
        ep0cs    <= '0;
        for (int e = 0; e < NUM_EP; e++) begin
          inl[e] <= '0; inh[e] <= '0; outl[e] <= '0; outh[e] <= '0;
        end
      end else if (cpu_wr) begin
        case (cpu_addr)
          A_ADDR: dev_addr <= cpu_wdata[6:0];
          A_IDX:  idx      <= cpu_wdata[IDX_W-1:0];
          A_CIE:  ie_mask  <= cpu_wdata[3:0];
          A_EP0:  ep0cs    <= cpu_wdata;
          A_INL:  if (ep_sel) inl[idx]  <= cpu_wdata;
          A_INH:  if (ep_sel) inh[idx]  <= cpu_wdata;
          A_OUTL: if (ep_sel) outl[idx] <= cpu_wdata;
          A_OUTH: if (ep_sel) outh[idx] <= cpu_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      A_ADDR: cpu_rdata = {1'b0, dev_addr};
      A_IDX:  cpu_rdata[IDX_W-1:0] = idx;
      A_CIF:  cpu_rdata[2] = rst_flag;
      A_CIE:  cpu_rdata[3:0] = ie_mask;
      A_CHF:  cpu_rdata[0] = chip_flag;
      A_GEN:  cpu_rdata[0] = glb_en;
      A_EP0:  cpu_rdata = ep0cs;
      A_INL:  cpu_rdata = ep_sel ? inl[idx]  : 8'h00;
      A_INH:  cpu_rdata = ep_sel ? inh[idx]  : 8'h00;
      A_OUTL: cpu_rdata = ep_sel ? outl[idx] : 8'h00;
      A_OUTH: cpu_rdata = ep_sel ? outh[idx] : 8'h00;
      default: ;
    endcase
  end

  a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> rst_flag);
  a_r1_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cif && !bus_rst_i) |=> !rst_flag);
  a_r2_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> glb_en);
  a_r2_chip_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_i && ie_mask[2]) |=> chip_flag);
  a_r3_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> dev_addr == 7'd0);
  a_r4_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> idx == '0);
  a_r6_ep0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> ep0cs == 8'h00);
  a_r7_mask_reload: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> ie_mask == RST_MASK);
  a_r5_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_i |-> $countones(flush_o) == 0);

endmodule

// File: tb/test_usb_busreset_regs.sv
module test_usb_busreset_regs;
  localparam int NUM_EP = 4;

  logic clk = 0, rst_n = 0, bus_rst = 0, wr = 0, rd = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [NUM_EP-1:0] flush;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  usb_busreset_regs #(.NUM_EP(NUM_EP)) i_usb_busreset_regs (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst), .cpu_addr(addr), .cpu_wr(wr),
    .cpu_rd(rd), .cpu_wdata(wdata), .cpu_rdata(rdata), .flush_o(flush), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input bit with_rst = 0);
    @(negedge clk); addr = a; wdata = d; wr = 1; bus_rst = with_rst;
    @(negedge clk); wr = 0; bus_rst = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  // peek without clearing
  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_rst();
    @(negedge clk); bus_rst = 1; #1
    chk(flush == '1, "R5 flush in reset cycle", flush, 4'hF);
    @(negedge clk); bus_rst = 0; #1
    chk(flush == '0, "R5 flush quiet after", flush, 0);
  endtask

  task automatic check_cleared(input string tag);
    peek(0, v); chk(v == 0, {tag, " R3 address"}, v, 0);
    peek(1, v); chk(v == 0, {tag, " R4 index"}, v, 0);
    peek(3, v); chk(v == 8'h06, {tag, " R7 mask"}, v, 8'h06);
    peek(6, v); chk(v == 0, {tag, " R6 ep0"}, v, 0);
    for (int e = 1; e < NUM_EP; e++) begin
      wr_reg(1, 8'(e));
      for (int r = 7; r <= 10; r++) begin
        peek(4'(r), v); chk(v == 0, {tag, " R6 endpoint reg"}, v, 0);
      end
    end
    wr_reg(1, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    for (int a = 0; a < 16; a++) begin
      peek(4'(a), v);
      chk(v == ((a == 3) ? 8'h06 : 8'h00), "R10 reset value", v, (a == 3) ? 6 : 0);
    end
    chk(irq == 0, "R10 irq low", irq, 0);

    // R3 address sweep with next-cycle visibility, then clear
    for (int a = 0; a < 128; a++) begin
      wr_reg(0, 8'(a) | 8'h80);
      peek(0, v); chk(v == 8'(a), "R3 address write", v, a);
    end
    pulse_rst();
    peek(0, v); chk(v == 0, "R3 address cleared", v, 0);

    // R6 per-endpoint registers under every index, then clear
    wr_reg(6, 8'hA5);
    for (int e = 0; e < NUM_EP; e++) begin
      wr_reg(1, 8'(e));
      for (int r = 7; r <= 10; r++) wr_reg(4'(r), 8'(16 * e + r));
    end
    for (int e = 0; e < NUM_EP; e++) begin
      wr_reg(1, 8'(e));
      for (int r = 7; r <= 10; r++) begin
        peek(4'(r), v);
        chk(v == ((e == 0) ? 8'h00 : 8'(16 * e + r)), "R6 endpoint write", v,
            (e == 0) ? 0 : 16 * e + r);
      end
    end
    wr_reg(0, 8'h33); wr_reg(3, 8'h0F); wr_reg(1, 8'd3);
    pulse_rst();
    check_cleared("single");

    // R1 read-to-clear and set-wins
    rd_reg(2, v); chk(v == 8'h04, "R1 flag set", v, 4);
    peek(2, v); chk(v == 0, "R1 flag cleared by read", v, 0);
    @(negedge clk); addr = 2; rd = 1; bus_rst = 1;
    @(negedge clk); rd = 0; bus_rst = 0;
    peek(2, v); chk(v == 8'h04, "R1 set wins over read", v, 4);
    rd_reg(2, v);

    // R2 enable chain sweep over all masks and global enable
    for (int g = 0; g < 2; g++) begin
      wr_reg(5, 8'(g));
      for (int m = 0; m < 16; m++) begin
        wr_reg(4, 8'h01);
        wr_reg(3, 8'(m));
        pulse_rst();
        peek(4, v); chk(v[0] == m[2], "R2 chip flag", v[0], m[2]);
        chk(irq == (m[2] & g[0]), "R2 irq gating", irq, m[2] & g);
        peek(3, v); chk(v == 8'h06, "R7 mask reload", v, 6);
        rd_reg(2, v);
      end
    end
    // R2 write-one-to-clear, and set wins
    wr_reg(4, 8'h01); peek(4, v); chk(v == 0, "R2 chip flag cleared", v, 0);
    chk(irq == 0, "R2 irq low after clear", irq, 0);
    wr_reg(4, 8'h01, 1); peek(4, v); chk(v == 1, "R2 set wins over clear", v, 1);
    chk(irq == 1, "R2 irq high", irq, 1);
    wr_reg(4, 8'h01); wr_reg(5, 0);

    // R9 writes in the reset cycle are dropped
    wr_reg(0, 8'h55, 1); peek(0, v); chk(v == 0, "R9 address write dropped", v, 0);
    wr_reg(1, 8'h02, 1); peek(1, v); chk(v == 0, "R9 index write dropped", v, 0);
    wr_reg(3, 8'h09, 1); peek(3, v); chk(v == 6, "R9 mask write dropped", v, 6);
    wr_reg(6, 8'h77, 1); peek(6, v); chk(v == 0, "R9 ep0 write dropped", v, 0);
    wr_reg(1, 8'h02);
    for (int r = 7; r <= 10; r++) begin
      wr_reg(4'(r), 8'h3C, 1);
      wr_reg(1, 8'h02);
      peek(4'(r), v); chk(v == 0, "R9 endpoint write dropped", v, 0);
    end

    // R8 repeated resets: back-to-back and interleaved with writes
    wr_reg(0, 8'h12); wr_reg(6, 8'h44); wr_reg(3, 8'h01);
    @(negedge clk); bus_rst = 1; #1 chk(flush == '1, "R8 flush first", flush, 15);
    @(negedge clk); #1 chk(flush == '1, "R8 flush second", flush, 15);
    @(negedge clk); bus_rst = 0;
    check_cleared("R8 back-to-back");
    wr_reg(0, 8'h21); wr_reg(6, 8'h99); wr_reg(1, 8'h01); wr_reg(7, 8'hEE); wr_reg(3, 8'h08);
    pulse_rst();
    wr_reg(0, 8'h22); wr_reg(6, 8'h98); wr_reg(1, 8'h01); wr_reg(8, 8'hED);
    pulse_rst();
    check_cleared("R8 interleaved");
    rd_reg(2, v); chk(v == 8'h04, "R8 flag after repeats", v, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule